// File: doc/BRIEF.md
# Power Partition Gating Controller

This block switches a set of on-chip power partitions on and off, tracks which of them have settled in the powered state, and controls the isolation clamps, clock enables and resets that each partition needs around a power transition. Software drives it through a small word-addressed register file. A write to the toggle register flips the power state of one partition. A read-only status word shows one bit per partition. A write-one-to-release mask lifts isolation clamps.

The analog power switch of each partition is modelled as a fixed settle delay. A built-in sequencer can bring one partition up completely. It first asserts reset, then applies power and waits for it to settle. It then enables the clock, waits, releases the clamp, waits again and releases reset. Each wait lasts a programmable number of cycles, with a floor of 10 microseconds at the configured clock rate. A fault reported during a wait unwinds the sequence in reverse order.

Two irregularities are kept deliberately. The clamp mask bits of the video-decode and PCIe partitions are crossed. The graphics partition can have its clamp moved to a dedicated register when a configuration input is high.

Register map (word addresses): 0 toggle (bit 8 go, bits 4:0 index), 1 status (read), 2 clamp release mask, 3 graphics clamp control, 4 sequencer start (bit 8 go, bits 4:0 index), 5 wait count (read/write).

Top module: `part_gate_ctrl`

## Requirements
- R1: After reset all partitions are unpowered (pwr_en_o=0), clamped (clamp_o all 1), clocks off, resets asserted (rst_o all 1), status reads 0, and busy_o, err_o, seq_busy_o and seq_fail_o are 0.
- R2: A write to address 0 with bit 8 set flips pwr_en_o of the partition given by bits 4:0 on the same clock edge. A write with bit 8 clear has no effect.
- R3: The status word at address 1 holds one bit per partition, where 1 means powered. A partition's bit takes the new power state exactly SETTLE_CYC cycles after the accepted toggle, and busy_o is 1 throughout those cycles.
- R4: A toggle request that arrives while busy_o is 1 is ignored.
- R5: A toggle or sequencer start whose index is at or above NUM_PART is ignored and sets err_o, which stays set until reset.
- R6: A write to address 2 releases the clamp of each powered partition whose mask bit is 1. Mask bits for unpowered partitions have no effect.
- R7: Mask bit VDEC_IDX releases partition PCIE_IDX, and mask bit PCIE_IDX releases partition VDEC_IDX.
- R8: While gfx_sep_clamp_i is 1, mask bit GFX_IDX is ignored. Writing 0 to address 3 releases the graphics clamp and writing a nonzero value re-asserts it. While gfx_sep_clamp_i is 0, writes to address 3 are ignored.
- R9: Power-on leaves the clamp asserted. On the edge where a partition powers off, its clamp is asserted, its clock is disabled and its reset is asserted.
- R10: A sequencer start asserts reset and powers the partition. After power settles it enables the clock, releases the clamp one wait later, and releases reset one more wait later.
- R11: Each sequencer wait lasts max(programmed count, 10*CLK_MHZ) cycles. The programmed count is read back at address 5.
- R12: A seq_fault_i seen during a sequencer wait disables the clock on that edge and removes power on the next edge. seq_fail_o is set, and reset and the clamp stay asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address (write and read) |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i |
| gfx_sep_clamp_i | input | 1 | Graphics clamp handled by its dedicated register |
| seq_fault_i | input | 1 | Fault during a sequencer wait |
| pwr_en_o | output | NUM_PART | Power switch enable per partition |
| clamp_o | output | NUM_PART | Isolation clamp per partition, 1 = clamped |
| clk_en_o | output | NUM_PART | Clock enable per partition |
| rst_o | output | NUM_PART | Reset per partition, 1 = held in reset |
| busy_o | output | 1 | Power switch settling |
| err_o | output | 1 | Sticky out-of-range index error |
| seq_busy_o | output | 1 | Sequencer running |
| seq_fail_o | output | 1 | Last sequence was aborted |

## Verification
A corrupted settle counter shows up as a status bit that changes one cycle early or late relative to the toggle write, or as a busy flag that lets a second toggle through. Both are visible within SETTLE_CYC cycles. A wrong clamp state appears at clamp_o on the edge after the offending mask write or power-off, and the crossed VDEC/PCIe bits are exercised in both directions. A sequencer that miscounts shifts the measured distances between the clock-enable, clamp-release and reset-release edges by whole cycles. A broken unwind leaves the clock enabled while power is removed, which is seen one edge after the fault.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam logic [2:0] A_TOGGLE = 3'd0;
  localparam logic [2:0] A_STATUS = 3'd1;
  localparam logic [2:0] A_UNCLMP = 3'd2;
  localparam logic [2:0] A_GFXCLP = 3'd3;
  localparam logic [2:0] A_SEQ    = 3'd4;
  localparam logic [2:0] A_WAIT   = 3'd5;

  localparam int GO_BIT      = 8;
  localparam int IDX_FIELD_W = 5;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PWR,
    SQ_W1,
    SQ_W2,
    SQ_UNDO
  } seq_st_e;
endpackage

// File: rtl/pgc_power_bank.sv
module pgc_power_bank #(
  parameter int N          = 8,
  parameter int SETTLE_CYC = 4,
  localparam int IW        = $clog2(N),
  localparam int CW        = $clog2(SETTLE_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tgl_req_i,
  input  logic [IW-1:0] tgl_idx_i,
  output logic [N-1:0]  pwr_en_o,
  output logic [N-1:0]  status_o,
  output logic          busy_o,
  output logic [N-1:0]  off_evt_o
);
  logic [N-1:0]  pwr_q, stat_q, sel;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign busy_o = (cnt_q != '0);
  assign accept = tgl_req_i & ~busy_o;

  always_comb begin
    for (int i = 0; i < N; i++) sel[i] = accept && (tgl_idx_i == IW'(i));
  end

  assign off_evt_o = sel & pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= '0;
      stat_q <= '0;
      cnt_q  <= '0;
    end else begin
      pwr_q <= pwr_q ^ sel;
      if (accept) cnt_q <= CW'(SETTLE_CYC);
      else if (busy_o) cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) stat_q <= pwr_q;
    end
  end

  assign pwr_en_o = pwr_q;
  assign status_o = stat_q;
endmodule

// File: rtl/pgc_clamp_unit.sv
module pgc_clamp_unit #(
  parameter int N        = 8,
  parameter int VDEC_IDX = 3,
  parameter int PCIE_IDX = 4,
  parameter int GFX_IDX  = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pwr_en_i,
  input  logic [N-1:0] off_evt_i,
  input  logic [N-1:0] seq_rel_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_i,
  input  logic         gfx_sep_i,
  input  logic         gfx_we_i,
  input  logic         gfx_zero_i,
  output logic [N-1:0] clamp_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // crossed mask lanes for the two swapped partitions
    localparam int SRC    = (i == VDEC_IDX) ? PCIE_IDX : (i == PCIE_IDX) ? VDEC_IDX : i;
    localparam bit IS_GFX = (i == GFX_IDX);

    logic shared_rel, ded_rel, ded_set, clamp_q;

    assign shared_rel = mask_we_i & mask_i[SRC] & ~(gfx_sep_i & IS_GFX);
    assign ded_rel    = IS_GFX & gfx_sep_i & gfx_we_i & gfx_zero_i;
    assign ded_set    = IS_GFX & gfx_sep_i & gfx_we_i & ~gfx_zero_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) clamp_q <= 1'b1;
      else if (off_evt_i[i]) clamp_q <= 1'b1;
      else if ((shared_rel | ded_rel | seq_rel_i[i]) & pwr_en_i[i]) clamp_q <= 1'b0;
      else if (ded_set) clamp_q <= 1'b1;
    end

    assign clamp_o[i] = clamp_q;
  end
endmodule

// File: rtl/pgc_sequencer.sv
module pgc_sequencer
  import pgc_pkg::*;
#(
  parameter int N      = 8,
  parameter int WAIT_W = 16,
  localparam int IW    = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IW-1:0]     start_idx_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [N-1:0]      pwr_en_i,
  input  logic              busy_i,
  input  logic              fault_i,
  input  logic [N-1:0]      off_evt_i,
  output logic              tgl_req_o,
  output logic [IW-1:0]     tgl_idx_o,
  output logic [N-1:0]      clamp_rel_o,
  output logic [N-1:0]      clk_en_o,
  output logic [N-1:0]      rst_o,
  output logic              seq_busy_o,
  output logic              seq_fail_o
);
  seq_st_e           st_q, st_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              fail_q, fail_d;
  logic              tgl_req, clk_set, clk_clr, rst_clr, clamp_rel;
  logic [N-1:0]      rst_set, oh, clk_q, rst_q;

  assign oh = N'(1) << idx_q;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; fail_d = fail_q;
    tgl_req = 1'b0; clk_set = 1'b0; clk_clr = 1'b0;
    rst_clr = 1'b0; clamp_rel = 1'b0; rst_set = '0;
    unique case (st_q)
      SQ_IDLE: if (start_i) begin
        st_d = SQ_PWR; idx_d = start_idx_i; fail_d = 1'b0;
        rst_set = N'(1) << start_idx_i;
      end
      SQ_PWR: if (!busy_i) begin
        if (pwr_en_i[idx_q]) begin
          clk_set = 1'b1; cnt_d = wait_i; st_d = SQ_W1;
        end else tgl_req = 1'b1;
      end
      SQ_W1: begin
        if (fault_i) begin
          clk_clr = 1'b1; st_d = SQ_UNDO;
        end else if (cnt_q == WAIT_W'(1)) begin
          clamp_rel = 1'b1; cnt_d = wait_i; st_d = SQ_W2;
        end else cnt_d = cnt_q - 1'b1;
      end
      SQ_W2: begin
        if (fault_i) begin
          clk_clr = 1'b1; st_d = SQ_UNDO;
        end else if (cnt_q == WAIT_W'(1)) begin
          rst_clr = 1'b1; st_d = SQ_IDLE;
        end else cnt_d = cnt_q - 1'b1;
      end
      SQ_UNDO: if (!busy_i) begin
        tgl_req = pwr_en_i[idx_q]; fail_d = 1'b1; st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      fail_q <= 1'b0;
      clk_q  <= '0;
      rst_q  <= '1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      fail_q <= fail_d;
      clk_q  <= (clk_q | (clk_set ? oh : '0)) & ~(clk_clr ? oh : '0) & ~off_evt_i;
      rst_q  <= (rst_q & ~(rst_clr ? oh : '0)) | rst_set | off_evt_i;
    end
  end

  assign tgl_req_o   = tgl_req;
  assign tgl_idx_o   = idx_q;
  assign clamp_rel_o = clamp_rel ? oh : '0;
  assign clk_en_o    = clk_q;
  assign rst_o       = rst_q;
  assign seq_busy_o  = (st_q != SQ_IDLE);
  assign seq_fail_o  = fail_q;
endmodule

// File: rtl/part_gate_ctrl.sv
module part_gate_ctrl
  import pgc_pkg::*;
#(
  parameter int NUM_PART   = 8,
  parameter int SETTLE_CYC = 4,
  parameter int CLK_MHZ    = 100,
  parameter int WAIT_W     = 16,
  parameter int GFX_IDX    = 1,
  parameter int VDEC_IDX   = 3,
  parameter int PCIE_IDX   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [2:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rd_data_o,
  input  logic                gfx_sep_clamp_i,
  input  logic                seq_fault_i,
  output logic [NUM_PART-1:0] pwr_en_o,
  output logic [NUM_PART-1:0] clamp_o,
  output logic [NUM_PART-1:0] clk_en_o,
  output logic [NUM_PART-1:0] rst_o,
  output logic                busy_o,
  output logic                err_o,
  output logic                seq_busy_o,
  output logic                seq_fail_o
);
  localparam int IW       = $clog2(NUM_PART);
  localparam int WAIT_MIN = 10 * CLK_MHZ;

  logic                wr_tgl, wr_seq, in_range, reg_tgl_ok, seq_start;
  logic                tgl_req, seq_tgl_req, err_q;
  logic [IW-1:0]       tgl_idx, seq_tgl_idx;
  logic [NUM_PART-1:0] status, off_evt, seq_rel;
  logic [WAIT_W-1:0]   wait_q, wait_eff;

  assign wr_tgl     = wr_en_i & (addr_i == A_TOGGLE) & wdata_i[GO_BIT];
  assign wr_seq     = wr_en_i & (addr_i == A_SEQ) & wdata_i[GO_BIT];
  assign in_range   = 32'(wdata_i[IDX_FIELD_W-1:0]) < NUM_PART;
  assign reg_tgl_ok = wr_tgl & in_range & ~seq_tgl_req;
  assign seq_start  = wr_seq & in_range;
  assign tgl_req    = seq_tgl_req | reg_tgl_ok;
  assign tgl_idx    = seq_tgl_req ? seq_tgl_idx : wdata_i[IW-1:0];
  assign wait_eff   = (wait_q < WAIT_W'(WAIT_MIN)) ? WAIT_W'(WAIT_MIN) : wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      wait_q <= WAIT_W'(WAIT_MIN);
    end else begin
      if ((wr_tgl | wr_seq) & ~in_range) err_q <= 1'b1;
      if (wr_en_i && addr_i == A_WAIT) wait_q <= wdata_i[WAIT_W-1:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_STATUS: rd_data_o = 32'(status);
      A_WAIT:   rd_data_o = 32'(wait_q);
      default:  rd_data_o = '0;
    endcase
  end

  pgc_power_bank #(.N(NUM_PART), .SETTLE_CYC(SETTLE_CYC)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tgl_req_i(tgl_req), .tgl_idx_i(tgl_idx),
    .pwr_en_o(pwr_en_o), .status_o(status),
    .busy_o(busy_o), .off_evt_o(off_evt)
  );

  pgc_clamp_unit #(.N(NUM_PART), .VDEC_IDX(VDEC_IDX), .PCIE_IDX(PCIE_IDX),
                   .GFX_IDX(GFX_IDX)) u_clamp (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pwr_en_i(pwr_en_o), .off_evt_i(off_evt), .seq_rel_i(seq_rel),
    .mask_we_i(wr_en_i && addr_i == A_UNCLMP), .mask_i(wdata_i[NUM_PART-1:0]),
    .gfx_sep_i(gfx_sep_clamp_i),
    .gfx_we_i(wr_en_i && addr_i == A_GFXCLP), .gfx_zero_i(wdata_i == '0),
    .clamp_o(clamp_o)
  );

  pgc_sequencer #(.N(NUM_PART), .WAIT_W(WAIT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(seq_start), .start_idx_i(wdata_i[IW-1:0]), .wait_i(wait_eff),
    .pwr_en_i(pwr_en_o), .busy_i(busy_o), .fault_i(seq_fault_i),
    .off_evt_i(off_evt),
    .tgl_req_o(seq_tgl_req), .tgl_idx_o(seq_tgl_idx), .clamp_rel_o(seq_rel),
    .clk_en_o(clk_en_o), .rst_o(rst_o),
    .seq_busy_o(seq_busy_o), .seq_fail_o(seq_fail_o)
  );

  assign err_o = err_q;
endmodule

// File: rtl/part_gate_ctrl_chk.sv
module part_gate_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] pwr_en_i,
  input logic [N-1:0] clamp_i,
  input logic [N-1:0] clk_en_i,
  input logic [N-1:0] status_i,
  input logic         busy_i,
  input logic         err_i
);
  p_unpowered_clamped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~pwr_en_i & ~clamp_i) == '0);

  p_clock_needs_power_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i & ~pwr_en_i) == '0);

  p_busy_blocks_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(pwr_en_i));

  p_status_after_settle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_i) |-> $fell(busy_i));

  p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_i) |-> err_i);
endmodule

bind part_gate_ctrl part_gate_ctrl_chk #(.N(NUM_PART)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_en_i(pwr_en_o), .clamp_i(clamp_o),
  .clk_en_i(clk_en_o), .status_i(status), .busy_i(busy_o), .err_i(err_o)
);

// File: tb/part_gate_ctrl_test.sv
module part_gate_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int SETTLE     = 4;
  localparam int WMIN       = 20;

  typedef struct packed {
    logic [2:0]  addr;
    logic [31:0] data;
    logic [7:0]  exp_pwr;
    logic [7:0]  exp_clamp;
    logic        exp_err;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{3'd0, 32'h100, 8'h01, 8'hFF, 1'b0},  // R2 on 0
    '{3'd0, 32'h005, 8'h01, 8'hFF, 1'b0},  // R2 no go bit
    '{3'd0, 32'h103, 8'h09, 8'hFF, 1'b0},  // R2 on 3
    '{3'd2, 32'h008, 8'h09, 8'hFF, 1'b0},  // R7 bit3 -> part4 unpowered
    '{3'd0, 32'h104, 8'h19, 8'hFF, 1'b0},  // R9 on leaves clamp
    '{3'd2, 32'h008, 8'h19, 8'hEF, 1'b0},  // R7 bit3 -> part4
    '{3'd2, 32'h011, 8'h19, 8'hE6, 1'b0},  // R6/R7 bit4 -> part3
    '{3'd0, 32'h103, 8'h11, 8'hEE, 1'b0},  // R9 off reclamps
    '{3'd0, 32'h109, 8'h11, 8'hEE, 1'b1},  // R5 out of range
    '{3'd0, 32'h100, 8'h10, 8'hEF, 1'b1}   // R2 off 0
  };

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, gfx_sep = 1'b0, fault = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] pwr_en, clamp, clk_en, rst;
  logic busy, err, seq_busy, seq_fail;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  part_gate_ctrl #(.NUM_PART(N), .SETTLE_CYC(SETTLE), .CLK_MHZ(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rd_data_o(rdata), .gfx_sep_clamp_i(gfx_sep), .seq_fault_i(fault),
    .pwr_en_o(pwr_en), .clamp_o(clamp), .clk_en_o(clk_en), .rst_o(rst),
    .busy_o(busy), .err_o(err), .seq_busy_o(seq_busy), .seq_fail_o(seq_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int t_pwr, t_clk, t_clmp, t_rst;
    logic rst_at_pwr;
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    rd(3'd1, r); chk("R1 status", r, 0);
    chk("R1 pwr_en", 32'(pwr_en), 0);
    chk("R1 clamp", 32'(clamp), 32'hFF);
    chk("R1 clk_en", 32'(clk_en), 0);
    chk("R1 rst", 32'(rst), 32'hFF);
    chk("R1 flags", {busy, err, seq_busy, seq_fail}, 0);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i].addr, VEC[i].data);
      idle(SETTLE + 1);
      rd(3'd1, r);
      chk($sformatf("R3 vec%0d status", i), r, 32'(VEC[i].exp_pwr));
      chk($sformatf("R2 vec%0d pwr_en", i), 32'(pwr_en), 32'(VEC[i].exp_pwr));
      chk($sformatf("R6 vec%0d clamp", i), 32'(clamp), 32'(VEC[i].exp_clamp));
      chk($sformatf("R5 vec%0d err", i), 32'(err), 32'(VEC[i].exp_err));
    end

    // R3 settle timing on partition 1
    wr(3'd0, 32'h101);
    rd(3'd1, r);
    chk("R3 pwr_en at once", 32'(pwr_en), 32'h12);
    chk("R3 busy set", 32'(busy), 1);
    chk("R3 status not yet", r, 32'h10);
    idle(SETTLE - 1);
    rd(3'd1, r);
    chk("R3 status before settle", r, 32'h10);
    chk("R3 still busy", 32'(busy), 1);
    idle(1);
    rd(3'd1, r);
    chk("R3 status settled", r, 32'h12);
    chk("R3 busy clear", 32'(busy), 0);

    // R4 toggle while busy
    wr(3'd0, 32'h102);
    wr(3'd0, 32'h101);
    idle(SETTLE + 2);
    chk("R4 ignored while busy", 32'(pwr_en), 32'h16);
    rd(3'd1, r); chk("R4 status", r, 32'h16);

    // R8 dedicated graphics clamp
    wr(3'd3, 32'h0);  idle(1); chk("R8 reg ignored sep=0", 32'(clamp), 32'hEF);
    wr(3'd2, 32'h2);  idle(1); chk("R8 shared bit sep=0", 32'(clamp), 32'hED);
    wr(3'd3, 32'h1);  idle(1); chk("R8 reg set ignored sep=0", 32'(clamp), 32'hED);
    gfx_sep = 1'b1;
    wr(3'd3, 32'h1);  idle(1); chk("R8 reg nonzero clamps", 32'(clamp), 32'hEF);
    wr(3'd2, 32'h2);  idle(1); chk("R8 shared bit ignored", 32'(clamp), 32'hEF);
    wr(3'd3, 32'h0);  idle(1); chk("R8 reg zero releases", 32'(clamp), 32'hED);
    gfx_sep = 1'b0;

    // R11 readback and floor
    wr(3'd5, 32'd5);
    rd(3'd5, r); chk("R11 wait readback", r, 5);

    // R10 sequence on partition 6 with floored wait
    wr(3'd4, 32'h106);
    t_pwr = -1; t_clk = -1; t_clmp = -1; t_rst = -1; rst_at_pwr = 1'b0;
    for (int n = 1; n < 200 && (n < 3 || seq_busy); n++) begin
      @(negedge clk);
      if (t_pwr < 0 && pwr_en[6]) begin t_pwr = n; rst_at_pwr = rst[6]; end
      if (t_clk < 0 && clk_en[6]) t_clk = n;
      if (t_clmp < 0 && !clamp[6]) t_clmp = n;
      if (t_rst < 0 && !rst[6]) t_rst = n;
    end
    chk("R10 reset held at power", 32'(rst_at_pwr), 1);
    chk("R10 power first", t_pwr, 1);
    chk("R10 clock after settle", t_clk - t_pwr, SETTLE + 1);
    chk("R11 clamp after floored wait", t_clmp - t_clk, WMIN);
    chk("R10 reset after wait", t_rst - t_clmp, WMIN);
    chk("R10 seq idle", {seq_busy, seq_fail}, 0);

    // R11 programmed wait above the floor, partition 5
    wr(3'd5, 32'd30);
    wr(3'd4, 32'h105);
    t_clk = -1; t_clmp = -1;
    for (int n = 1; n < 300 && (n < 3 || seq_busy); n++) begin
      @(negedge clk);
      if (t_clk < 0 && clk_en[5]) t_clk = n;
      if (t_clmp < 0 && !clamp[5]) t_clmp = n;
    end
    chk("R11 programmed wait", t_clmp - t_clk, 30);
    chk("R10 reset released 5", 32'(rst[5]), 0);

    // R5 sequencer start out of range
    wr(3'd4, 32'h10A);
    chk("R5 seq out of range ignored", 32'(seq_busy), 0);

    // R12 fault unwinds partition 7
    wr(3'd5, 32'd0);
    wr(3'd4, 32'h107);
    for (int n = 0; n < 100 && !clk_en[7]; n++) @(negedge clk);
    idle(3);
    fault = 1'b1;
    @(negedge clk); fault = 1'b0;
    chk("R12 clock off first", 32'(clk_en[7]), 0);
    chk("R12 power still on", 32'(pwr_en[7]), 1);
    @(negedge clk);
    chk("R12 power off next", 32'(pwr_en[7]), 0);
    chk("R12 fail flag", {seq_fail, seq_busy}, 2'b10);
    chk("R12 clamp and reset held", {clamp[7], rst[7]}, 2'b11);

    // R9 register power-off of a sequenced partition
    idle(SETTLE + 1);
    wr(3'd0, 32'h106);
    chk("R9 off clamps", 32'(clamp[6]), 1);
    chk("R9 off clock", 32'(clk_en[6]), 0);
    chk("R9 off reset", 32'(rst[6]), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule